// File: doc/BRIEF.md
# AXI Handshake Efficiency Counter Bank

This block sits beside one AXI4 memory port and only watches it. On each clock it samples the read-data-valid and write-data-valid indications and the six address and data handshake lines. It keeps one unsigned counter for each of these eight events, and one more counter for elapsed cycles. Read activity and write activity are counted apart. The handshake counters show how often the memory side holds transfers back.

The cycle counter stops when it reaches its largest value. On that same cycle every event counter also stops, so each ratio of an event count to the cycle count stays exact however long the traffic runs. A synchronous clear sets the whole set back to zero. A host reads the counters through a plain address-in, data-out register port that answers one cycle later. A memory with many channels uses one instance of this block per channel.

Top module: `axi_eff_ctr_bank`

## Requirements
- R1: While rst_ni is low, every counter, the saturated flag and reg_rdata_o are zero.
- R2: The counter at word offset 1 adds one in each counted cycle in which rd_dvalid_i is high. The counter at offset 2 does the same for wr_dvalid_i.
- R3: The cycle counter at offset 0 adds one on every clock edge while clr_i is low. It stops at 2^CNT_W-1 and never wraps.
- R4: The handshake counters add one in each counted cycle in which their line is high. Their word offsets are: 3 for rready_i, 4 for wready_i, 5 for arvalid_i, 6 for awvalid_i, 7 for arready_i and 8 for awready_i.
- R5: Once the cycle counter holds 2^CNT_W-1, no event counter changes until the next clear. On the edge that brings the cycle counter to its maximum, event counters still count.
- R6: An event counter never wraps, and it never exceeds the cycle counter.
- R7: On an edge with clr_i high, all counters go to zero and the saturated flag clears. Counting resumes on the first edge with clr_i low.
- R8: Offset 9 returns the saturated flag in bit 0, with all other bits zero. Offsets 10 to 15 return zero.
- R9: reg_rdata_o shows, one cycle after reg_addr_i is presented, the value the addressed register held at the edge that captured the address. Reads never change any counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the counter set |
| rd_dvalid_i | input | 1 | Read data valid |
| wr_dvalid_i | input | 1 | Write data valid |
| rready_i | input | 1 | Read data ready |
| wready_i | input | 1 | Write data ready |
| arvalid_i | input | 1 | Read address valid |
| awvalid_i | input | 1 | Write address valid |
| arready_i | input | 1 | Read address ready |
| awready_i | input | 1 | Write address ready |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_rdata_o | output | CNT_W | Register read data, one cycle latency |

## Verification
The assertions rely on every sampled input being a known 0 or 1 at each rising edge, and on reg_addr_i being known while it is read. Nothing about the AXI protocol is assumed: each line may take any value in any cycle. The stimulus drives all inputs, including clear and address, on the falling edge from arithmetic patterns. It never leaves a line undriven. A narrow counter width lets the bench reach saturation and run past it within a short run.

// File: rtl/eff_ctr_pkg.sv
package eff_ctr_pkg;
  localparam int NUM_EVT = 8;
  // event index; register offset = index + 1
  typedef enum int {
    EV_RD_DVALID = 0,
    EV_WR_DVALID = 1,
    EV_RREADY    = 2,
    EV_WREADY    = 3,
    EV_ARVALID   = 4,
    EV_AWVALID   = 5,
    EV_ARREADY   = 6,
    EV_AWREADY   = 7
  } evt_idx_e;
  localparam int OFS_TOTAL  = 0;
  localparam int OFS_EVT0   = 1;
  localparam int OFS_STATUS = OFS_EVT0 + NUM_EVT;
endpackage

// File: rtl/eff_sat_ctr.sv
module eff_sat_ctr #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         max_o
);
  localparam logic [W-1:0] MAX_V = '1;
  logic [W-1:0] cnt_q;

  assign max_o = (cnt_q == MAX_V);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (inc_i && !max_o)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/eff_ctr_set.sv
module eff_ctr_set
  import eff_ctr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            clr_i,
  input  logic [NUM_EVT-1:0]              evt_i,
  output logic [CNT_W-1:0]                tot_o,
  output logic [NUM_EVT-1:0][CNT_W-1:0]   evt_cnt_o,
  output logic                            sat_o
);
  logic tot_max;

  eff_sat_ctr #(.W(CNT_W)) i_tot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .inc_i  (1'b1),
    .cnt_o  (tot_o),
    .max_o  (tot_max)
  );

  assign sat_o = tot_max;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    logic unused_max;
    // events count only in cycles the total still counts
    eff_sat_ctr #(.W(CNT_W)) i_evt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_i),
      .inc_i  (evt_i[g] & ~tot_max),
      .cnt_o  (evt_cnt_o[g]),
      .max_o  (unused_max)
    );
  end
endmodule

// File: rtl/eff_reg_port.sv
module eff_reg_port
  import eff_ctr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [CNT_W-1:0]              tot_i,
  input  logic [NUM_EVT-1:0][CNT_W-1:0] evt_cnt_i,
  input  logic                          sat_i,
  output logic [CNT_W-1:0]              rdata_o
);
  logic [CNT_W-1:0] rdata_d, rdata_q;

  always_comb begin
    rdata_d = '0;
    if (addr_i == ADDR_W'(OFS_TOTAL))  rdata_d = tot_i;
    if (addr_i == ADDR_W'(OFS_STATUS)) rdata_d = {{(CNT_W-1){1'b0}}, sat_i};
    for (int i = 0; i < NUM_EVT; i++) begin
      if (addr_i == ADDR_W'(OFS_EVT0 + i)) rdata_d = evt_cnt_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/axi_eff_ctr_bank.sv
module axi_eff_ctr_bank
  import eff_ctr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              rd_dvalid_i,
  input  logic              wr_dvalid_i,
  input  logic              rready_i,
  input  logic              wready_i,
  input  logic              arvalid_i,
  input  logic              awvalid_i,
  input  logic              arready_i,
  input  logic              awready_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  output logic [CNT_W-1:0]  reg_rdata_o
);
  logic [NUM_EVT-1:0]            evt_vec;
  logic [CNT_W-1:0]              tot_cnt;
  logic [NUM_EVT-1:0][CNT_W-1:0] evt_cnt;
  logic                          tot_sat;

  always_comb begin
    evt_vec               = '0;
    evt_vec[EV_RD_DVALID] = rd_dvalid_i;
    evt_vec[EV_WR_DVALID] = wr_dvalid_i;
    evt_vec[EV_RREADY]    = rready_i;
    evt_vec[EV_WREADY]    = wready_i;
    evt_vec[EV_ARVALID]   = arvalid_i;
    evt_vec[EV_AWVALID]   = awvalid_i;
    evt_vec[EV_ARREADY]   = arready_i;
    evt_vec[EV_AWREADY]   = awready_i;
  end

  eff_ctr_set #(.CNT_W(CNT_W)) i_set (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .evt_i     (evt_vec),
    .tot_o     (tot_cnt),
    .evt_cnt_o (evt_cnt),
    .sat_o     (tot_sat)
  );

  eff_reg_port #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_port (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (reg_addr_i),
    .tot_i     (tot_cnt),
    .evt_cnt_i (evt_cnt),
    .sat_i     (tot_sat),
    .rdata_o   (reg_rdata_o)
  );
endmodule

// File: rtl/eff_ctr_chk.sv
module eff_ctr_chk
  import eff_ctr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          clr_i,
  input logic [NUM_EVT-1:0]            evt_i,
  input logic [CNT_W-1:0]              tot_i,
  input logic [NUM_EVT-1:0][CNT_W-1:0] evt_cnt_i,
  input logic                          sat_i,
  input logic [ADDR_W-1:0]             addr_i,
  input logic [CNT_W-1:0]              rdata_i
);
  localparam logic [CNT_W-1:0] MAX_V = '1;
  logic all_le;

  always_comb begin
    all_le = 1'b1;
    for (int i = 0; i < NUM_EVT; i++)
      if (evt_cnt_i[i] > tot_i) all_le = 1'b0;
  end

  // R1
  always_comb
    if (!rst_ni) reset_zero_chk: assert (tot_i == '0 && rdata_i == '0 && !sat_i);

  // R3
  tot_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && tot_i != MAX_V) |=> tot_i == $past(tot_i) + 1'b1);

  // R3
  tot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && tot_i == MAX_V) |=> tot_i == MAX_V);

  // R2
  rd_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && tot_i != MAX_V && evt_i[EV_RD_DVALID])
      |=> evt_cnt_i[EV_RD_DVALID] == $past(evt_cnt_i[EV_RD_DVALID]) + 1'b1);

  // R4
  awr_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !evt_i[EV_AWREADY]) |=> $stable(evt_cnt_i[EV_AWREADY]));

  // R5
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && sat_i) |=> $stable(evt_cnt_i));

  // R6
  evt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) all_le);

  // R7
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (tot_i == '0 && evt_cnt_i == '0 && !sat_i));

  // R8
  status_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(OFS_STATUS)) |=> rdata_i == CNT_W'($past(sat_i)));

  // R9
  total_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(OFS_TOTAL)) |=> rdata_i == $past(tot_i));
endmodule

bind axi_eff_ctr_bank eff_ctr_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_eff_ctr_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clr_i     (clr_i),
  .evt_i     (evt_vec),
  .tot_i     (tot_cnt),
  .evt_cnt_i (evt_cnt),
  .sat_i     (tot_sat),
  .addr_i    (reg_addr_i),
  .rdata_i   (reg_rdata_o)
);

// File: tb/test_axi_eff_ctr_bank.sv
module test_axi_eff_ctr_bank;
  localparam int CNT_W  = 8;
  localparam int ADDR_W = 4;
  localparam int MAX_V  = (1 << CNT_W) - 1;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              clr_i = 1'b0;
  logic [7:0]        ev = '0;
  logic [ADDR_W-1:0] reg_addr_i = '0;
  logic [CNT_W-1:0]  reg_rdata_o;

  int checks = 0;
  int errors = 0;
  int m_tot = 0;
  int m_ev[8];
  string phase_tag = "R1";

  always #5 clk_i = ~clk_i;

  axi_eff_ctr_bank #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_axi_eff_ctr_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr_i),
    .rd_dvalid_i (ev[0]),
    .wr_dvalid_i (ev[1]),
    .rready_i    (ev[2]),
    .wready_i    (ev[3]),
    .arvalid_i   (ev[4]),
    .awvalid_i   (ev[5]),
    .arready_i   (ev[6]),
    .awready_i   (ev[7]),
    .reg_addr_i  (reg_addr_i),
    .reg_rdata_o (reg_rdata_o)
  );

  function automatic int model_rd(input int a);
    if (a == 0) return m_tot;
    if (a >= 1 && a <= 8) return m_ev[a-1];
    if (a == 9) return (m_tot == MAX_V) ? 1 : 0;
    return 0;
  endfunction

  function automatic string addr_tag(input int a);
    if (a == 0) return "R3";
    if (a <= 2) return (m_tot == MAX_V) ? "R5" : "R2";
    if (a <= 8) return (m_ev[a-1] == MAX_V) ? "R6" : "R4";
    return "R8";
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model at posedge, check read at next negedge (R9)
  task automatic step(input logic clr, input logic [7:0] e, input int a);
    int exp_rd;
    string tg;
    clr_i = clr;
    ev = e;
    reg_addr_i = ADDR_W'(a);
    @(posedge clk_i);
    exp_rd = model_rd(a);
    tg = addr_tag(a);
    if (clr) begin
      m_tot = 0;
      foreach (m_ev[i]) m_ev[i] = 0;
    end else if (m_tot < MAX_V) begin
      m_tot++;
      for (int i = 0; i < 8; i++) if (e[i] && m_ev[i] < MAX_V) m_ev[i]++;
    end
    @(negedge clk_i);
    check({phase_tag, "/", tg, "/R9"}, int'(reg_rdata_o), exp_rd);
  endtask

  function automatic logic [7:0] pat(input int k, input int sel);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      case (sel)
        0: r[i] = ((k * (i + 3)) >> 2) % 2 == 1;
        1: r[i] = (k % (i + 2)) == 0;
        default: r[i] = 1'b1;
      endcase
    end
    return r;
  endfunction

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog R1 actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    foreach (m_ev[i]) m_ev[i] = 0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1", int'(reg_rdata_o), 0);
    rst_ni = 1'b1;
    phase_tag = "R2";
    for (int k = 0; k < 120; k++) step(1'b0, pat(k, 0), k % 16);
    // R7 clear held for several cycles, reads through it
    phase_tag = "R7";
    for (int k = 0; k < 4; k++) step(1'b1, 8'hff, k % 10);
    for (int k = 0; k < 16; k++) step(1'b0, 8'h00, k);
    // R3 R5 run to saturation and beyond
    phase_tag = "R5";
    for (int k = 0; k < 400; k++) step(1'b0, pat(k, 1), k % 16);
    // R6 all events every cycle, count to maximum
    phase_tag = "R7";
    step(1'b1, 8'h00, 0);
    phase_tag = "R6";
    for (int k = 0; k < 300; k++) step(1'b0, pat(k, 2), (k * 7) % 16);
    // R8 status sweep after saturation
    phase_tag = "R8";
    for (int a = 9; a < 16; a++) step(1'b0, 8'hff, a);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule